// File: doc/BRIEF.md
# Sensor Row Readout Sequencer

This block drives a column-parallel image sensor through a complete frame, one row at a time. It issues a one-cycle active-low conversion strobe with a row address. It waits for the sensor's active-low conversion-done line to fall. It then lowers the load/shift control and the read gate together and captures one wide data word per clock for a fixed number of beats. Each captured word goes onto a simple valid/data stream. Flags mark the first and last beat of a row, and the row index travels with the data.

The conversion of the next row is started while the current row is still being shifted out. The sequencer can do this because the sensor keeps converted data in an output register that is separate from the converters. A frame is started by a single-cycle start pulse. It ends with a frame-done pulse on the last beat of the last row. If the sensor never reports a conversion done, a programmable timeout raises an error pulse and the conversion side returns to idle.

Top module: `sensor_row_seq`

## Requirements
- R1: While reset is asserted, and until a start pulse arrives, `conv_start_n`, `xfer_n` and `read_gate_n` are high, and `px_valid`, `frame_done` and `timeout_err` are low.
- R2: A start pulse while idle issues a one-cycle low pulse on `conv_start_n` with `row_sel` = 0. Each later conversion pulse carries the previous address plus one, up to NUM_ROWS-1.
- R3: `row_sel` does not change from the cycle of a conversion pulse until the sensor's done line has fallen.
- R4: `xfer_n` goes low only after a falling edge of `conv_done_n` has been seen for the row being read, and at most once per such edge.
- R5: `xfer_n` and `read_gate_n` fall in the same cycle and stay low together. They are released on the clock edge that captures the last of the BEATS words, so they stay low for exactly BEATS+2 cycles.
- R6: Word k of a row (k = 0..BEATS-1) is sampled from `sens_data` on the (3+k)-th rising edge after `xfer_n` goes low. It appears on `px_data` with `px_valid` high in the following cycle.
- R7: On each valid word, `px_row` gives the row it came from. `px_sor` is 1 only on word 0 and `px_eor` is 1 only on word BEATS-1.
- R8: When rows remain in the frame, the next conversion pulse occurs exactly two cycles after `read_gate_n` falls for the current row.
- R9: `frame_done` is a one-cycle pulse. It occurs together with the end-of-row word of row NUM_ROWS-1 and at no other time.
- R10: If `conv_done_n` does not fall within `timeout_cycles` cycles after a conversion pulse, `timeout_err` pulses exactly `timeout_cycles` cycles after that pulse. No further conversion pulse follows, and a later start pulse begins a new frame at row 0.
- R11: A start pulse that arrives while a frame is in progress, or while a readout is still running, is ignored. The row sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a frame at row 0 |
| timeout_cycles | input | TO_W | Cycles allowed between a conversion pulse and the done edge |
| conv_done_n | input | 1 | Sensor's active-low conversion-done line |
| sens_data | input | BUS_W | Sensor output data word |
| row_sel | output | ROW_W | Row address sent to the sensor |
| conv_start_n | output | 1 | Active-low one-cycle conversion strobe |
| xfer_n | output | 1 | Active-low load/shift control |
| read_gate_n | output | 1 | Active-low output read gate |
| px_valid | output | 1 | Stream word valid |
| px_data | output | BUS_W | Stream word |
| px_sor | output | 1 | Start-of-row marker |
| px_eor | output | 1 | End-of-row marker |
| px_row | output | ROW_W | Row index of the stream word |
| frame_done | output | 1 | Pulse on the last word of the frame |
| timeout_err | output | 1 | Pulse when a conversion times out |

## Verification
The bench varies the sensor's conversion latency across frames. In short-latency frames the done edge arrives while the previous row is still shifting out. A design that loaded as soon as done fell would cut that readout short or load the wrong row. In long-latency frames the readout sits idle between rows, which exposes any design that lowers the load control without a fresh done edge. Every stream word is compared with the word the sensor model drove for that row and beat. A latency that is off by one cycle therefore shows up as shifted data and a misplaced start-of-row flag. One frame suppresses the done edge of a middle row to measure the exact timeout cycle and confirm that no conversion follows. A start pulse injected in mid-frame would show up as a restart at row 0.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        CV_IDLE  = 2'd0,
        CV_WAIT  = 2'd1,
        CV_HELD  = 2'd2,
        CV_TRAIL = 2'd3
    } conv_st_e;

endpackage

// File: rtl/srs_conv_ctrl.sv
module srs_conv_ctrl
    import srs_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int NUM_ROWS = 1024,
    parameter int TO_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             accept,
    input  logic             launch,
    input  logic [TO_W-1:0]  timeout_cycles,
    input  logic             row_done_n,
    output logic             row_strt_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             row_ready,
    output logic             err_pulse,
    output logic             conv_idle
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    typedef struct packed {
        conv_st_e         st;
        logic [ROW_W-1:0] addr;
        logic             strt_n;
        logic [TO_W-1:0]  cnt;
        logic             done_prev;
        logic             err;
    } conv_regs_t;

    conv_regs_t conv_d, conv_q;
    logic       done_fall;
    logic       expired;

    always_comb begin
        conv_d           = conv_q;
        conv_d.strt_n    = 1'b1;
        conv_d.err       = 1'b0;
        conv_d.done_prev = row_done_n;
        done_fall        = conv_q.done_prev & ~row_done_n;
        expired          = ({1'b0, conv_q.cnt} + 1'b1) >= {1'b0, timeout_cycles};
        case (conv_q.st)
            CV_IDLE: begin
                if (start) begin
                    conv_d.st     = CV_WAIT;
                    conv_d.addr   = '0;
                    conv_d.strt_n = 1'b0;
                    conv_d.cnt    = '0;
                end
            end
            CV_WAIT: begin
                if (done_fall) begin
                    conv_d.st = CV_HELD;
                end else if (expired) begin
                    conv_d.st  = CV_IDLE;
                    conv_d.err = 1'b1;
                end else begin
                    conv_d.cnt = conv_q.cnt + 1'b1;
                end
            end
            CV_HELD: begin
                if (accept) begin
                    conv_d.st = CV_TRAIL;
                end
            end
            CV_TRAIL: begin
                if (launch) begin
                    if (conv_q.addr == LAST_ROW) begin
                        conv_d.st = CV_IDLE;
                    end else begin
                        conv_d.st     = CV_WAIT;
                        conv_d.addr   = conv_q.addr + 1'b1;
                        conv_d.strt_n = 1'b0;
                        conv_d.cnt    = '0;
                    end
                end
            end
            default: conv_d.st = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_q.st        <= CV_IDLE;
            conv_q.addr      <= '0;
            conv_q.strt_n    <= 1'b1;
            conv_q.cnt       <= '0;
            conv_q.done_prev <= 1'b1;
            conv_q.err       <= 1'b0;
        end else begin
            conv_q <= conv_d;
        end
    end

    assign row_strt_n = conv_q.strt_n;
    assign row_addr   = conv_q.addr;
    assign row_ready  = (conv_q.st == CV_HELD);
    assign err_pulse  = conv_q.err;
    assign conv_idle  = (conv_q.st == CV_IDLE);

    // R2: the conversion strobe lasts exactly one cycle
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_q.strt_n |=> conv_q.strt_n);

    // R2: strobed address stays inside the frame
    a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_q.strt_n |-> (conv_q.addr <= LAST_ROW));

    // R3: address is held while waiting for the done edge
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_q.st == CV_WAIT && $past(conv_q.st) == CV_WAIT) |-> $stable(conv_q.addr));

    // R10: a timeout leaves the controller idle with no strobe
    a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_q.err |-> (conv_q.st == CV_IDLE && conv_q.strt_n));

endmodule

// File: rtl/srs_readout.sv
module srs_readout #(
    parameter int ROW_W    = 10,
    parameter int NUM_ROWS = 1024,
    parameter int BEATS    = 128,
    parameter int BUS_W    = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [ROW_W-1:0] row_in,
    input  logic [BUS_W-1:0] bus_data,
    output logic             ro_idle,
    output logic             launch,
    output logic             ld_n,
    output logic             rd_n,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_data,
    output logic             out_sor,
    output logic             out_eor,
    output logic [ROW_W-1:0] out_row,
    output logic             frame_done
);

    localparam int               BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(NUM_ROWS - 1);
    localparam logic [1:0]        LAT_LAST  = 2'd2;

    typedef struct packed {
        logic              active;
        logic [1:0]        lat;
        logic [BEAT_W-1:0] beat;
        logic [ROW_W-1:0]  row;
        logic              ld_n;
        logic              rd_n;
        logic              ov;
        logic [BUS_W-1:0]  od;
        logic              osor;
        logic              oeor;
        logic [ROW_W-1:0]  orow;
        logic              fdone;
    } ro_regs_t;

    ro_regs_t ro_d, ro_q;

    always_comb begin
        ro_d       = ro_q;
        ro_d.ov    = 1'b0;
        ro_d.osor  = 1'b0;
        ro_d.oeor  = 1'b0;
        ro_d.fdone = 1'b0;
        if (!ro_q.active) begin
            if (accept) begin
                ro_d.active = 1'b1;
                ro_d.lat    = '0;
                ro_d.beat   = '0;
                ro_d.row    = row_in;
                ro_d.ld_n   = 1'b0;
                ro_d.rd_n   = 1'b0;
            end
        end else if (ro_q.lat != LAT_LAST) begin
            ro_d.lat = ro_q.lat + 2'd1;
        end else begin
            ro_d.ov   = 1'b1;
            ro_d.od   = bus_data;
            ro_d.osor = (ro_q.beat == '0);
            ro_d.oeor = (ro_q.beat == LAST_BEAT);
            ro_d.orow = ro_q.row;
            if (ro_q.beat == LAST_BEAT) begin
                ro_d.active = 1'b0;
                ro_d.ld_n   = 1'b1;
                ro_d.rd_n   = 1'b1;
                ro_d.fdone  = (ro_q.row == LAST_ROW);
            end else begin
                ro_d.beat = ro_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ro_q.active <= 1'b0;
            ro_q.lat    <= '0;
            ro_q.beat   <= '0;
            ro_q.row    <= '0;
            ro_q.ld_n   <= 1'b1;
            ro_q.rd_n   <= 1'b1;
            ro_q.ov     <= 1'b0;
            ro_q.od     <= '0;
            ro_q.osor   <= 1'b0;
            ro_q.oeor   <= 1'b0;
            ro_q.orow   <= '0;
            ro_q.fdone  <= 1'b0;
        end else begin
            ro_q <= ro_d;
        end
    end

    assign ro_idle    = !ro_q.active;
    assign launch     = ro_q.active && (ro_q.lat == 2'd1);
    assign ld_n       = ro_q.ld_n;
    assign rd_n       = ro_q.rd_n;
    assign out_valid  = ro_q.ov;
    assign out_data   = ro_q.od;
    assign out_sor    = ro_q.osor;
    assign out_eor    = ro_q.oeor;
    assign out_row    = ro_q.orow;
    assign frame_done = ro_q.fdone;

    // R5: load control is released only after the final capture
    a_r5_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ro_q.ld_n) |-> ($past(ro_q.beat) == LAST_BEAT && $past(ro_q.lat) == LAT_LAST));

    // R5: load and read gate move together
    a_r5_gate_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ro_q.ld_n) |-> $fell(ro_q.rd_n));

    // R6: a stream word only follows a cycle with load held low
    a_r6_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        ro_q.ov |-> $past(!ro_q.ld_n));

    // R9: frame completion coincides with the last word of the last row
    a_r9_frame_on_eor: assert property (@(posedge clk) disable iff (!rst_n)
        ro_q.fdone |-> (ro_q.ov && ro_q.oeor && ro_q.orow == LAST_ROW));

    // R7: start and end markers never share a word
    a_r7_marker_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_q.ov && ro_q.osor) |-> !ro_q.oeor);

endmodule

// File: rtl/sensor_row_seq.sv
module sensor_row_seq #(
    parameter int ROW_W    = 10,
    parameter int NUM_ROWS = 1024,
    parameter int BEATS    = 128,
    parameter int BUS_W    = 100,
    parameter int TO_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TO_W-1:0]  timeout_cycles,
    input  logic             conv_done_n,
    input  logic [BUS_W-1:0] sens_data,
    output logic [ROW_W-1:0] row_sel,
    output logic             conv_start_n,
    output logic             xfer_n,
    output logic             read_gate_n,
    output logic             px_valid,
    output logic [BUS_W-1:0] px_data,
    output logic             px_sor,
    output logic             px_eor,
    output logic [ROW_W-1:0] px_row,
    output logic             frame_done,
    output logic             timeout_err
);

    logic ro_idle;
    logic launch;
    logic row_ready;
    logic conv_idle;
    logic accept;
    logic start_go;

    assign accept   = row_ready & ro_idle;
    assign start_go = start & ro_idle;

    srs_conv_ctrl #(
        .ROW_W    (ROW_W),
        .NUM_ROWS (NUM_ROWS),
        .TO_W     (TO_W)
    ) conv_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start_go),
        .accept         (accept),
        .launch         (launch),
        .timeout_cycles (timeout_cycles),
        .row_done_n     (conv_done_n),
        .row_strt_n     (conv_start_n),
        .row_addr       (row_sel),
        .row_ready      (row_ready),
        .err_pulse      (timeout_err),
        .conv_idle      (conv_idle)
    );

    srs_readout #(
        .ROW_W    (ROW_W),
        .NUM_ROWS (NUM_ROWS),
        .BEATS    (BEATS),
        .BUS_W    (BUS_W)
    ) ro_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .row_in     (row_sel),
        .bus_data   (sens_data),
        .ro_idle    (ro_idle),
        .launch     (launch),
        .ld_n       (xfer_n),
        .rd_n       (read_gate_n),
        .out_valid  (px_valid),
        .out_data   (px_data),
        .out_sor    (px_sor),
        .out_eor    (px_eor),
        .out_row    (px_row),
        .frame_done (frame_done)
    );

    // R11: a frame is only ever started from a fully idle block
    a_r11_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(conv_start_n) && row_sel == '0) |-> $past(conv_idle && ro_idle));

endmodule

// File: tb/sensor_row_seq_tb_top.sv
`timescale 1ns/1ps
module sensor_row_seq_tb_top;

    localparam int ROW_W = 10;
    localparam int NROWS = 8;
    localparam int BEATS = 128;
    localparam int BUS_W = 100;
    localparam int TO_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [TO_W-1:0]  timeout_cycles = 16'd400;
    logic             conv_done_n = 1'b1;
    logic [BUS_W-1:0] sens_data = '0;
    logic [ROW_W-1:0] row_sel;
    logic             conv_start_n;
    logic             xfer_n;
    logic             read_gate_n;
    logic             px_valid;
    logic [BUS_W-1:0] px_data;
    logic             px_sor;
    logic             px_eor;
    logic [ROW_W-1:0] px_row;
    logic             frame_done;
    logic             timeout_err;

    always #2 clk = ~clk;

    sensor_row_seq #(
        .ROW_W(ROW_W), .NUM_ROWS(NROWS), .BEATS(BEATS), .BUS_W(BUS_W), .TO_W(TO_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_cycles(timeout_cycles),
        .conv_done_n(conv_done_n), .sens_data(sens_data), .row_sel(row_sel),
        .conv_start_n(conv_start_n), .xfer_n(xfer_n), .read_gate_n(read_gate_n),
        .px_valid(px_valid), .px_data(px_data), .px_sor(px_sor), .px_eor(px_eor),
        .px_row(px_row), .frame_done(frame_done), .timeout_err(timeout_err)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench state
    int cyc = 0;
    int exp_strobe_row = 0;
    int conv_row = 0;
    int done_cnt = 0;
    bit waiting = 1'b0;
    int ready_row = 0;
    bit ready_pending = 1'b0;
    int read_row = 0;
    int ldcnt = 0;
    int gate_fall_cyc = 0;
    int strobe_cyc = 0;
    int strobes_total = 0;
    int orow_exp = 0;
    int obeat = 0;
    int frames_done = 0;
    int errs_seen = 0;
    int cur_timeout = 400;
    int suppress_row = -1;
    int lat_lo = 5;
    int lat_hi = 60;
    bit busy_start_pending = 1'b0;
    bit prev_strt_n = 1'b1;
    bit prev_gate_n = 1'b1;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    function automatic logic [BUS_W-1:0] pix(input int row, input int beat);
        logic [BUS_W-1:0] v;
        logic [31:0]      w;
        v = '0;
        for (int i = 0; i < 4; i++) begin
            w = (32'(row) * 32'd131 + 32'(beat) * 32'd7 + 32'(i)) * 32'h9E3779B1;
            v = (v << 32) ^ {{(BUS_W-32){1'b0}}, w ^ 32'h5A5A0F0F};
        end
        return v;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // sensor model and stream checker
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!conv_start_n) begin
                chk(prev_strt_n, "R2 strobe not single-cycle", 0, 1);
                chk(int'(row_sel) == exp_strobe_row, "R2 row sequence", row_sel, exp_strobe_row);
                if (busy_start_pending) begin
                    chk(int'(row_sel) == exp_strobe_row, "R11 busy start restarted frame",
                        row_sel, exp_strobe_row);
                    busy_start_pending = 1'b0;
                end
                if (row_sel != 0)
                    chk(cyc - gate_fall_cyc == 2, "R8 overlap spacing", cyc - gate_fall_cyc, 2);
                exp_strobe_row++;
                strobe_cyc = cyc;
                strobes_total++;
                conv_row = int'(row_sel);
                conv_done_n = 1'b1;
                waiting = 1'b1;
                if (int'(row_sel) == suppress_row) done_cnt = -1;
                else done_cnt = int'($urandom_range(lat_hi, lat_lo));
            end else if (waiting) begin
                chk(int'(row_sel) == conv_row, "R3 address moved", row_sel, conv_row);
                if (done_cnt > 0) begin
                    done_cnt--;
                    if (done_cnt == 0) begin
                        conv_done_n = 1'b0;
                        ready_row = conv_row;
                        ready_pending = 1'b1;
                        waiting = 1'b0;
                    end
                end
            end

            if (!xfer_n) begin
                ldcnt++;
                if (ldcnt == 1) begin
                    chk(ready_pending, "R4 load without done edge", 0, 1);
                    read_row = ready_row;
                    ready_pending = 1'b0;
                end
            end else begin
                if (ldcnt != 0)
                    chk(ldcnt == BEATS + 2, "R5 load low length", ldcnt, BEATS + 2);
                ldcnt = 0;
            end
            if (xfer_n != read_gate_n)
                chk(1'b0, "R5 load and gate differ", read_gate_n, xfer_n);
            if (!read_gate_n && prev_gate_n) gate_fall_cyc = cyc;

            if (ldcnt >= 3 && ldcnt < 3 + BEATS) sens_data = pix(read_row, ldcnt - 3);
            else sens_data = {$urandom, $urandom, $urandom, $urandom};

            if (px_valid) begin
                if (obeat == 0)
                    chk(ldcnt == 4, "R6 first word latency", ldcnt, 4);
                chk(px_data == pix(orow_exp, obeat), "R6 data word", px_data, pix(orow_exp, obeat));
                chk(int'(px_row) == orow_exp, "R7 row index", px_row, orow_exp);
                chk(px_sor == (obeat == 0), "R7 start marker", px_sor, obeat == 0);
                chk(px_eor == (obeat == BEATS - 1), "R7 end marker", px_eor, obeat == BEATS - 1);
                chk(frame_done == (obeat == BEATS - 1 && orow_exp == NROWS - 1),
                    "R9 frame done placement", frame_done,
                    (obeat == BEATS - 1 && orow_exp == NROWS - 1));
                if (obeat == BEATS - 1) begin
                    obeat = 0;
                    orow_exp++;
                end else begin
                    obeat++;
                end
            end else if (frame_done) begin
                chk(1'b0, "R9 frame done without word", 1, 0);
            end
            if (frame_done) frames_done++;

            if (timeout_err) begin
                chk(cyc - strobe_cyc == cur_timeout, "R10 timeout latency",
                    cyc - strobe_cyc, cur_timeout);
                chk(int'(row_sel) == suppress_row, "R10 timed out row", row_sel, suppress_row);
                errs_seen++;
            end
            prev_strt_n = conv_start_n;
            prev_gate_n = read_gate_n;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_frame(input int lo, input int hi, input int to, input bit busy_poke);
        int base;
        @(negedge clk);
        lat_lo = lo;
        lat_hi = hi;
        cur_timeout = to;
        timeout_cycles = TO_W'(to);
        exp_strobe_row = 0;
        orow_exp = 0;
        obeat = 0;
        base = frames_done;
        pulse_start();
        if (busy_poke) begin
            repeat (300) @(posedge clk);
            @(negedge clk) busy_start_pending = 1'b1;
            pulse_start();
        end
        for (int i = 0; i < 20000 && frames_done == base; i++) @(posedge clk);
        chk(frames_done == base + 1, "R9 frame completed", frames_done - base, 1);
        chk(orow_exp == NROWS, "R2 all rows streamed", orow_exp, NROWS);
        repeat (5) @(posedge clk);
    endtask

    initial begin
        #600000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(conv_start_n && xfer_n && read_gate_n, "R1 strobes high in reset",
                {conv_start_n, xfer_n, read_gate_n}, 3'b111);
            chk(!px_valid && !frame_done && !timeout_err, "R1 outputs low in reset",
                {px_valid, frame_done, timeout_err}, 0);
        end
        @(negedge clk) rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(conv_start_n && xfer_n && read_gate_n && !px_valid, "R1 idle after reset",
            {conv_start_n, xfer_n, read_gate_n, px_valid}, 4'b1110);

        // medium latency, with a start poked mid-frame
        run_frame(5, 60, 400, 1'b1);
        // very short latency: done waits for the busy readout
        run_frame(1, 3, 400, 1'b0);
        // long latency: readout idles between rows
        run_frame(180, 260, 400, 1'b0);

        // timeout on row 3
        begin
            int err_base;
            int str_at_err;
            int fd_at_err;
            @(negedge clk);
            suppress_row = 3;
            lat_lo = 5;
            lat_hi = 60;
            cur_timeout = 300;
            timeout_cycles = 16'd300;
            exp_strobe_row = 0;
            orow_exp = 0;
            obeat = 0;
            err_base = errs_seen;
            pulse_start();
            for (int i = 0; i < 5000 && errs_seen == err_base; i++) @(posedge clk);
            chk(errs_seen == err_base + 1, "R10 error raised", errs_seen - err_base, 1);
            str_at_err = strobes_total;
            fd_at_err = frames_done;
            repeat (400) @(posedge clk);
            chk(strobes_total == str_at_err, "R10 no strobe after error",
                strobes_total, str_at_err);
            chk(frames_done == fd_at_err, "R10 no frame done after error",
                frames_done, fd_at_err);
            chk(orow_exp == 3, "R10 rows before stall streamed", orow_exp, 3);
            @(negedge clk) suppress_row = -1;
        end

        // recovery frame after the timeout
        run_frame(1, 120, 200, 1'b0);
        chk(frames_done == 4, "R9 frame count", frames_done, 4);
        chk(errs_seen == 1, "R10 single error overall", errs_seen, 1);
        finish_run();
    end

endmodule